// File: doc/BRIEF.md
# Atomic-Update General-Purpose I/O Port

This block is a general-purpose I/O port with a parameterised pin count (32 by default) that sits on a simple synchronous register bus. It holds an output data register and a direction register, one bit per pin. A direction bit of 1 makes its pin an output, and a direction bit of 0 makes it an input. Each pin input passes through a two-flop synchronizer and can then be read back through an input data register.

Software often needs to change one output pin while an interrupt handler or another task changes a different pin. A read-modify-write sequence is unsafe in that case. For this reason the port also decodes three write-only alias registers: set, clear and invert. A mask written to one of them acts only on the output bits whose mask bit is 1 and leaves every other bit as it was. To drive pin n to a chosen level, software writes the one-hot value 1<<n to the set register or to the clear register.

Each bus access is accepted in the cycle that `bus_valid` is high. `bus_ready` and `bus_rdata` answer one cycle later.

Top module: `gpio_port`

## Requirements
- R1: During reset and on the first cycle after it, `pin_out`, `pin_oe`, `bus_ready` and `bus_rdata` are all zero, so every pin starts as an input whose output value is low.
- R2: A write to word address 1 (direction) replaces every direction bit. `pin_oe` shows the new value after the accepting clock edge, and a read of address 1 returns it.
- R3: A write to word address 0 (output data) replaces all output bits. `pin_out` shows the new value after the accepting edge, and a read of address 0 returns it.
- R4: A write of mask M to word address 3 (set) makes the output value `old | M`.
- R5: A write of mask M to word address 4 (clear) makes the output value `old & ~M`.
- R6: A write of mask M to word address 5 (invert) makes the output value `old ^ M`.
- R7: Reads of addresses 3, 4 and 5, and of the unmapped addresses 6 and 7, return zero. Writes to addresses 2, 6 and 7 change neither the output data nor the direction.
- R8: A read of word address 2 (input data) returns bit n = 1 when pin n is high. Because of the two-flop synchronizer, a read accepted at the first clock edge after a pin change still returns the old level, and a read accepted at the third edge returns the new level.
- R9: `bus_ready` is high in exactly the cycles that follow a cycle with `bus_valid` high. `bus_rdata` is valid when `bus_ready` is high and is zero after a write.
- R10: The output data does not change in any cycle without an accepted write to address 0, 3, 4 or 5. The direction does not change in any cycle without an accepted write to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access request, accepted on the same edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | PIN_COUNT | Write data or mask |
| bus_rdata | output | PIN_COUNT | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access complete, one cycle after acceptance |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output data driven to the pads |
| pin_oe | output | PIN_COUNT | Per-pin output enable (direction) |

## Verification
The alias registers are exercised with a one-hot mask on every pin, starting from both all-zero and all-one output values. This separates a correct single-bit update from a whole-word overwrite or a neighbouring bit being disturbed. Dense checkerboard masks applied over checkerboard contents catch operators that are swapped, such as OR used where XOR belongs or a missing inversion in clear. The input path is tried with walking-one and walking-zero pin patterns to confirm bit ordering. A read taken just after a pin change confirms the synchronizer latency. Writes to read-only and unmapped addresses, followed by read-backs, confirm that no register is touched.

// File: rtl/gpio_port_pkg.sv
// Shared constants for the I/O port: register word addresses and
// the address width. Offsets are part of the software contract.
package gpio_port_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_OUT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_IN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SET  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_INV  = 3'd5;

    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_OUT  = 2'd1,
        RD_DIR  = 2'd2,
        RD_IN   = 2'd3
    } rd_src_e;
endpackage

// File: rtl/gpio_bus_decode.sv
// Address decoder: turns one bus access into per-register write strobes
// and a read-source select. Assumes at most one access per cycle.
module gpio_bus_decode
    import gpio_port_pkg::*;
(
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              we_out,
    output logic              we_dir,
    output logic              we_set,
    output logic              we_clr,
    output logic              we_inv,
    output rd_src_e           rd_src
);
    logic wr;
    assign wr = acc_valid && acc_write;

    // Write strobe per writable register.
    always_comb begin
        we_out = wr && (acc_addr == A_OUT);
        we_dir = wr && (acc_addr == A_DIR);
        we_set = wr && (acc_addr == A_SET);
        we_clr = wr && (acc_addr == A_CLR);
        we_inv = wr && (acc_addr == A_INV);
    end

    // Read source; aliases and unmapped words read zero.
    always_comb begin
        rd_src = RD_ZERO;
        if (acc_valid && !acc_write) begin
            case (acc_addr)
                A_OUT:   rd_src = RD_OUT;
                A_DIR:   rd_src = RD_DIR;
                A_IN:    rd_src = RD_IN;
                default: rd_src = RD_ZERO;
            endcase
        end
    end
endmodule

// File: rtl/gpio_out_reg.sv
// Output data and direction storage. The output word accepts a full
// replace or masked set / clear / invert updates. Should several
// strobes coincide (possible only with separate ports), a full write
// wins, then clear beats set, then invert is applied last.
module gpio_out_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_out,
    input  logic         we_dir,
    input  logic         we_set,
    input  logic         we_clr,
    input  logic         we_inv,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q
);
    logic [W-1:0] set_m, clr_m, inv_m, out_d;

    // Masks are zero unless their strobe is active.
    always_comb begin
        set_m = we_set ? wdata : '0;
        clr_m = we_clr ? wdata : '0;
        inv_m = we_inv ? wdata : '0;
        if (we_out) out_d = wdata;
        else        out_d = ((out_q | set_m) & ~clr_m) ^ inv_m;
    end

    // Output data register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    // Direction register; 1 = output.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (we_dir) dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer per pin input. Assumes pins are asynchronous
// single bits with no required mutual coherence.
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        // Two-stage capture of one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= pin_raw[i];
                sync_q <= meta_q;
            end
        end
        assign pin_sync[i] = sync_q;
    end
endmodule

// File: rtl/gpio_port.sv
// General-purpose I/O port top. Registers: output data, direction,
// synchronized input data, and write-only set/clear/invert aliases.
// Each access is accepted when bus_valid is high; ready and read data
// follow one cycle later. Assumes one access per cycle.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [PIN_COUNT-1:0] bus_wdata,
    output logic [PIN_COUNT-1:0] bus_rdata,
    output logic                 bus_ready,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);
    logic we_out, we_dir, we_set, we_clr, we_inv;
    rd_src_e rd_src;
    logic [PIN_COUNT-1:0] out_q, dir_q, in_s, rd_d;

    gpio_bus_decode u_dec (
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_addr  (bus_addr),
        .we_out    (we_out),
        .we_dir    (we_dir),
        .we_set    (we_set),
        .we_clr    (we_clr),
        .we_inv    (we_inv),
        .rd_src    (rd_src)
    );

    gpio_out_reg #(.W(PIN_COUNT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_out (we_out),
        .we_dir (we_dir),
        .we_set (we_set),
        .we_clr (we_clr),
        .we_inv (we_inv),
        .wdata  (bus_wdata),
        .out_q  (out_q),
        .dir_q  (dir_q)
    );

    gpio_in_sync #(.W(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_sync (in_s)
    );

    // Read data select.
    always_comb begin
        case (rd_src)
            RD_OUT:  rd_d = out_q;
            RD_DIR:  rd_d = dir_q;
            RD_IN:   rd_d = in_s;
            default: rd_d = '0;
        endcase
    end

    // Registered bus response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_valid;
            bus_rdata <= rd_d;
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_checker.sv
// Port-level properties of the I/O port, bound to every gpio_port.
module gpio_port_checker
    import gpio_port_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [PIN_COUNT-1:0] bus_wdata,
    input logic [PIN_COUNT-1:0] bus_rdata,
    input logic                 bus_ready,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe
);
    logic wr_any;
    assign wr_any = bus_valid && bus_write;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && !bus_ready));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata));

    assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_OUT) |=> pin_out == $past(bus_wdata));

    assert_set_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_SET) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    assert_clr_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_CLR) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

    assert_inv_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_INV) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

    assert_alias_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr >= A_SET) |=> bus_rdata == '0);

    assert_ready_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ready);

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ready);

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && (bus_addr == A_OUT || bus_addr == A_SET ||
                     bus_addr == A_CLR || bus_addr == A_INV)) |=> $stable(pin_out));

    assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && bus_addr == A_DIR) |=> $stable(pin_oe));
endmodule

bind gpio_port gpio_port_checker #(.PIN_COUNT(PIN_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_bench.sv
// Self-checking bench: sweeps one-hot and patterned masks through every
// register and compares against an arithmetic model of the port.
module gpio_port_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic          bus_ready;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic [N-1:0] exp_out = '0;
    logic [N-1:0] exp_dir = '0;
    logic [N-1:0] rd;

    always #2 clk = ~clk;

    gpio_port #(.PIN_COUNT(N)) u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write: driven at a falling edge, accepted at the next rising edge.
    task automatic bus_wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R9 ready after write", {31'd0, bus_ready}, 32'd1);
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        check("R9 ready after read", {31'd0, bus_ready}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] pat;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_out in reset", pin_out, '0);
        check("R1 pin_oe in reset", pin_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin_out after reset", pin_out, '0);
        check("R1 ready idle", {31'd0, bus_ready}, 32'd0);
        check("R1 rdata idle", bus_rdata, '0);

        // R2: direction register
        foreach (pat[k]) begin end
        for (int p = 0; p < 4; p++) begin
            pat = (p == 0) ? 32'hA5A5_5A5A : (p == 1) ? 32'hFFFF_FFFF :
                  (p == 2) ? 32'h0000_0001 : 32'h8000_0000;
            bus_wr(3'd1, pat); exp_dir = pat;
            check("R2 pin_oe", pin_oe, exp_dir);
            bus_rd(3'd1, rd);
            check("R2 dir readback", rd, exp_dir);
            check("R10 out unchanged by dir write", pin_out, exp_out);
        end

        // R3: full output write
        for (int p = 0; p < 3; p++) begin
            pat = (p == 0) ? 32'h1234_5678 : (p == 1) ? 32'hFFFF_FFFF : 32'h0;
            bus_wr(3'd0, pat); exp_out = pat;
            check("R3 pin_out", pin_out, exp_out);
            bus_rd(3'd0, rd);
            check("R3 out readback", rd, exp_out);
            check("R10 dir unchanged by out write", pin_oe, exp_dir);
        end

        // R4/R5/R6: one-hot sweeps from both backgrounds
        for (int bg = 0; bg < 2; bg++) begin
            for (int i = 0; i < N; i++) begin
                bus_wr(3'd0, bg ? '1 : '0); exp_out = bg ? '1 : '0;
                bus_wr(3'd3, 32'd1 << i); exp_out = exp_out | (32'd1 << i);
                check("R4 set one-hot", pin_out, exp_out);
                bus_wr(3'd5, 32'd1 << i); exp_out = exp_out ^ (32'd1 << i);
                check("R6 invert one-hot", pin_out, exp_out);
                bus_wr(3'd5, 32'd1 << i); exp_out = exp_out ^ (32'd1 << i);
                check("R6 invert back", pin_out, exp_out);
                bus_wr(3'd4, 32'd1 << i); exp_out = exp_out & ~(32'd1 << i);
                check("R5 clear one-hot", pin_out, exp_out);
            end
        end

        // R4/R5/R6: dense masks over patterned contents
        for (int p = 0; p < 4; p++) begin
            logic [N-1:0] base, m;
            base = (p[0]) ? 32'hAAAA_AAAA : 32'h0F0F_0F0F;
            m    = (p[1]) ? 32'h5555_5555 : 32'h00FF_FF00;
            bus_wr(3'd0, base); exp_out = base;
            bus_wr(3'd3, m); exp_out = exp_out | m;
            check("R4 set mask", pin_out, exp_out);
            bus_wr(3'd0, base); exp_out = base;
            bus_wr(3'd4, m); exp_out = exp_out & ~m;
            check("R5 clear mask", pin_out, exp_out);
            bus_wr(3'd0, base); exp_out = base;
            bus_wr(3'd5, m); exp_out = exp_out ^ m;
            check("R6 invert mask", pin_out, exp_out);
            bus_rd(3'd0, rd);
            check("R6 readback after invert", rd, exp_out);
        end

        // R7: alias and unmapped reads zero; writes to 2/6/7 ignored
        for (int a = 2; a < 8; a++) begin
            bus_wr(a[2:0], 32'hDEAD_BEEF);
            if (a == 3) exp_out = exp_out | 32'hDEAD_BEEF;
            if (a == 4) exp_out = exp_out & ~32'hDEAD_BEEF;
            if (a == 5) exp_out = exp_out ^ 32'hDEAD_BEEF;
            check("R7 out after write to other address", pin_out, exp_out);
            check("R7 dir after write to other address", pin_oe, exp_dir);
            if (a >= 3) begin
                bus_rd(a[2:0], rd);
                check("R7 alias/unmapped reads zero", rd, '0);
            end
        end
        bus_rd(3'd0, rd);
        check("R7 out readback intact", rd, exp_out);
        bus_rd(3'd1, rd);
        check("R7 dir readback intact", rd, exp_dir);

        // R9: write response data is zero
        bus_wr(3'd3, '0);
        check("R9 rdata zero after write", bus_rdata, '0);

        // R8: walking one and walking zero on pins
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < N; i++) begin
                pin_in = w ? ~(32'd1 << i) : (32'd1 << i);
                repeat (3) @(negedge clk);
                bus_rd(3'd2, rd);
                check("R8 input level", rd, pin_in);
            end
        end

        // R8: synchronizer latency
        @(negedge clk);
        pat = pin_in;
        pin_in = 32'hC3C3_3C3C;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd2;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R8 first-edge read returns old level", bus_rdata, pat);
        bus_rd(3'd2, rd);
        check("R8 third-edge read returns new level", rd, 32'hC3C3_3C3C);
        check("R10 out unchanged by reads", pin_out, exp_out);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule